// File: doc/BRIEF.md
# Lock-Step Warp Issue Scheduler

This block picks, once per clock, which of several resident warps sends its next instruction to a shared dispatch port. A warp is 32 threads that share one program counter and run in lock-step. Each thread has an active bit, and the dispatch port receives the warp number, the opcode, two register indices and the active mask. A launch port fills an empty warp slot with a start address and an initial mask. The scheduler reads instructions through a combinational instruction-memory port, driving the address of the warp it is about to issue.

Memory instructions are sent over four consecutive turns of eight lanes each, because load/store throughput is a quarter of arithmetic width. After its last turn, a load parks its warp until a per-warp completion pulse arrives. Other warps keep issuing meanwhile, which hides the latency.

Divergence is handled with a small reconvergence stack in each warp. A conditional narrows the mask to the threads whose condition bit is set. A loop-back branch drops threads whose condition bit is clear. When the next PC meets the saved reconvergence address, the saved mask comes back. The control state machine has two states. `ST_SELECT` picks a ready warp by round robin, issues any single-turn instruction and moves to `ST_MEMTURN` on a memory opcode. `ST_MEMTURN` sends turns 1 to 3 of that instruction and returns to `ST_SELECT` after the last turn.

Top module: `warp_sched`

## Requirements
- R1: After reset no warp is resident, `idle` is 1 and `disp_valid` is 0.
- R2: A launch into a free slot makes that warp eligible in the next cycle, with the given PC and mask. A launch into an occupied slot is ignored.
- R3: A warp issues its instructions in program order. Every non-branching instruction advances its PC by one. A masked thread still costs the warp its issue slot.
- R4: Among ready warps (resident and not stalled), the winner is the first one found in circular order starting after the last warp granted. After reset the search starts at warp 0.
- R5: A LOAD or STORE holds the dispatch port for 4 consecutive cycles, with `disp_turn` running 0 to 3. In turn t, `disp_mask` is the warp's active mask limited to bits 8t to 8t+7. All four turns are spent even when a slice is empty, and no other warp issues in between.
- R6: After its final turn, a LOAD stalls its warp until `mem_done[w]` is seen. Other ready warps issue while it waits. A STORE does not stall.
- R7: IF with target T saves the current mask and T on the warp's stack and continues at PC+1 with mask AND `br_cond`. If that product is zero, it jumps to T with the mask unchanged and saves nothing.
- R8: Whenever a warp's next PC equals the reconvergence address on top of its stack, the saved mask is restored and the entry is removed. Reconvergence addresses of nested entries must be distinct. The stack holds 4 entries, and a save into a full stack is dropped.
- R9: MARK with target T saves the mask and T and continues at PC+1. LOOP with target S branches to S with mask AND `br_cond` when that product is non-zero. Otherwise it falls through to PC+1.
- R10: EXIT clears the warp's mask and frees its slot. `idle` is 1 exactly when the scheduler is choosing and no warp is ready.
- R11: The instruction word has the opcode in bits 19:16, rd in 15:11, rs in 10:6 and the target in 5:0. The opcodes are ALU=0, LOAD=1, STORE=2, IF=3, MARK=4, LOOP=5, EXIT=6, and any other value behaves as ALU. `imem_addr` is the PC of the warp being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_en | input | 1 | Launch request |
| launch_warp | input | 2 | Slot to fill |
| launch_pc | input | 6 | Start address |
| launch_mask | input | 32 | Initial active mask |
| br_cond | input | 32 | Per-thread condition for IF and LOOP |
| mem_done | input | 4 | Per-warp load completion pulse |
| imem_addr | output | 6 | Instruction fetch address |
| imem_data | input | 20 | Instruction word at `imem_addr` |
| disp_valid | output | 1 | Dispatch slot used this cycle |
| disp_warp | output | 2 | Issuing warp |
| disp_op | output | 4 | Opcode |
| disp_rd | output | 5 | Destination register index |
| disp_rs | output | 5 | Source register index |
| disp_mask | output | 32 | Active threads for this turn |
| disp_turn | output | 2 | Memory turn number, 0 for single-turn ops |
| idle | output | 1 | No warp ready |

## Verification
The hardest situation to reach from the ports is latency hiding: one warp sits parked on a load while a second warp is issued in its place. Reaching it takes two warps running the same load program, launched a cycle apart. Their interleaving is decided by round robin. The completion pulses are then returned in the opposite order to the issue, which shows the later warp resuming first. Nested mask changes inside a loop are reached by changing `br_cond` on each LOOP issue, so that the active set shrinks over two iterations before the full mask is restored.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    typedef enum logic [3:0] {
        OP_ALU   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_IF    = 4'd3,
        OP_MARK  = 4'd4,
        OP_LOOP  = 4'd5,
        OP_EXIT  = 4'd6
    } op_e;

    typedef enum logic {
        ST_SELECT,
        ST_MEMTURN
    } sched_st_e;

    function automatic logic is_mem_op(logic [3:0] op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] last,
    output logic                 any,
    output logic [$clog2(N)-1:0] pick
);
    localparam int IW = $clog2(N);

    // Scan from farthest to nearest so the nearest requester after 'last' wins.
    always_comb begin
        any  = 1'b0;
        pick = last;
        for (int off = N; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % N;
            if (req[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/warp_ctx.sv
module warp_ctx
    import warp_sched_pkg::*;
#(
    parameter int THREADS = 32,
    parameter int PC_W    = 6,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [PC_W-1:0]    launch_pc,
    input  logic [THREADS-1:0] launch_mask,
    input  logic               upd,
    input  logic [3:0]         upd_op,
    input  logic [PC_W-1:0]    upd_tgt,
    input  logic [THREADS-1:0] cond,
    input  logic               set_stall,
    input  logic               clr_stall,
    output logic               valid,
    output logic               stalled,
    output logic [PC_W-1:0]    pc,
    output logic [THREADS-1:0] mask
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [THREADS-1:0] stk_mask [DEPTH];
    logic [PC_W-1:0]    stk_pc   [DEPTH];
    logic [SP_W-1:0]    sp;

    logic [THREADS-1:0] taken, nmask;
    logic [PC_W-1:0]    npc;
    logic               nvalid, push, pop;
    logic [IDX_W-1:0]   top_idx;

    always_comb begin
        taken   = mask & cond;
        npc     = pc + 1'b1;
        nmask   = mask;
        nvalid  = valid;
        push    = 1'b0;
        top_idx = IDX_W'(sp - 1'b1);
        unique case (upd_op)
            OP_IF: begin
                if (taken == '0) begin
                    npc = upd_tgt;
                end else begin
                    push  = 1'b1;
                    nmask = taken;
                end
            end
            OP_MARK: push = 1'b1;
            OP_LOOP: begin
                if (taken != '0) begin
                    npc   = upd_tgt;
                    nmask = taken;
                end
            end
            OP_EXIT: begin
                nvalid = 1'b0;
                nmask  = '0;
            end
            default: ;
        endcase
        pop = (sp != '0) && !push && (upd_op != OP_EXIT) && (npc == stk_pc[top_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            stalled <= 1'b0;
            pc      <= '0;
            mask    <= '0;
            sp      <= '0;
        end else begin
            if (launch && !valid) begin
                valid   <= 1'b1;
                stalled <= 1'b0;
                pc      <= launch_pc;
                mask    <= launch_mask;
                sp      <= '0;
            end else if (upd) begin
                valid <= nvalid;
                pc    <= npc;
                mask  <= pop ? stk_mask[top_idx] : nmask;
                if (push && (sp < SP_W'(DEPTH))) begin
                    stk_mask[IDX_W'(sp)] <= mask;
                    stk_pc[IDX_W'(sp)]   <= upd_tgt;
                    sp                   <= sp + 1'b1;
                end else if (pop) begin
                    sp <= sp - 1'b1;
                end
            end
            if (set_stall)
                stalled <= 1'b1;
            else if (clr_stall)
                stalled <= 1'b0;
        end
    end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int WARPS     = 4,
    parameter int THREADS   = 32,
    parameter int LSU_LANES = 8,
    parameter int PC_W      = 6,
    parameter int REG_W     = 5,
    parameter int DEPTH     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                launch_en,
    input  logic [$clog2(WARPS)-1:0]            launch_warp,
    input  logic [PC_W-1:0]                     launch_pc,
    input  logic [THREADS-1:0]                  launch_mask,
    input  logic [THREADS-1:0]                  br_cond,
    input  logic [WARPS-1:0]                    mem_done,
    output logic [PC_W-1:0]                     imem_addr,
    input  logic [4+2*REG_W+PC_W-1:0]           imem_data,
    output logic                                disp_valid,
    output logic [$clog2(WARPS)-1:0]            disp_warp,
    output logic [3:0]                          disp_op,
    output logic [REG_W-1:0]                    disp_rd,
    output logic [REG_W-1:0]                    disp_rs,
    output logic [THREADS-1:0]                  disp_mask,
    output logic [$clog2(THREADS/LSU_LANES)-1:0] disp_turn,
    output logic                                idle
);
    localparam int WID_W   = $clog2(WARPS);
    localparam int TURNS   = THREADS / LSU_LANES;
    localparam int TURN_W  = $clog2(TURNS);
    localparam int INSTR_W = 4 + 2 * REG_W + PC_W;
    localparam logic [THREADS-1:0] LANE_ONES = {{(THREADS-LSU_LANES){1'b0}}, {LSU_LANES{1'b1}}};
    localparam logic [TURN_W-1:0]  LAST_TURN = TURN_W'(TURNS - 1);

    sched_st_e          state, next_state;
    logic [WID_W-1:0]   cur_warp, last_grant, pick, sel_warp;
    logic [TURN_W-1:0]  turn, turn_cur;
    logic [INSTR_W-1:0] cur_instr, instr;
    logic               any_ready;

    logic [WARPS-1:0]   valid_vec, stall_vec, ready, upd_vec, stall_set;
    logic [PC_W-1:0]    pc_arr   [WARPS];
    logic [THREADS-1:0] mask_arr [WARPS];

    logic [3:0]         op;
    logic [PC_W-1:0]    tgt;

    assign ready = valid_vec & ~stall_vec;

    warp_rr_pick #(.N(WARPS)) u_pick (
        .req  (ready),
        .last (last_grant),
        .any  (any_ready),
        .pick (pick)
    );

    for (genvar g = 0; g < WARPS; g++) begin : g_warp
        warp_ctx #(.THREADS(THREADS), .PC_W(PC_W), .DEPTH(DEPTH)) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .launch      (launch_en && (launch_warp == WID_W'(g))),
            .launch_pc   (launch_pc),
            .launch_mask (launch_mask),
            .upd         (upd_vec[g]),
            .upd_op      (op),
            .upd_tgt     (tgt),
            .cond        (br_cond),
            .set_stall   (stall_set[g]),
            .clr_stall   (mem_done[g]),
            .valid       (valid_vec[g]),
            .stalled     (stall_vec[g]),
            .pc          (pc_arr[g]),
            .mask        (mask_arr[g])
        );
    end

    assign sel_warp  = (state == ST_MEMTURN) ? cur_warp : pick;
    assign turn_cur  = (state == ST_MEMTURN) ? turn : '0;
    assign imem_addr = pc_arr[sel_warp];
    assign instr     = (state == ST_MEMTURN) ? cur_instr : imem_data;
    assign op        = instr[INSTR_W-1 -: 4];
    assign tgt       = instr[PC_W-1:0];

    // State register and per-issue bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SELECT;
            cur_warp   <= '0;
            last_grant <= WID_W'(WARPS - 1);
            turn       <= '0;
            cur_instr  <= '0;
        end else begin
            state <= next_state;
            if (state == ST_SELECT && any_ready) begin
                last_grant <= pick;
                cur_warp   <= pick;
                cur_instr  <= imem_data;
                turn       <= TURN_W'(1);
            end else if (state == ST_MEMTURN) begin
                turn <= turn + 1'b1;
            end
        end
    end

    // Outputs and transitions.
    always_comb begin
        next_state = state;
        disp_valid = 1'b0;
        idle       = 1'b0;
        upd_vec    = '0;
        stall_set  = '0;
        disp_warp  = sel_warp;
        disp_op    = op;
        disp_rd    = instr[INSTR_W-5 -: REG_W];
        disp_rs    = instr[INSTR_W-5-REG_W -: REG_W];
        disp_turn  = turn_cur;
        disp_mask  = mask_arr[sel_warp];
        unique case (state)
            ST_SELECT: begin
                if (any_ready) begin
                    disp_valid = 1'b1;
                    if (is_mem_op(op)) begin
                        disp_mask  = mask_arr[sel_warp] & LANE_ONES;
                        next_state = ST_MEMTURN;
                    end else begin
                        upd_vec[sel_warp] = 1'b1;
                    end
                end else begin
                    idle = 1'b1;
                end
            end
            ST_MEMTURN: begin
                disp_valid = 1'b1;
                disp_mask  = mask_arr[sel_warp] & (LANE_ONES << (int'(turn) * LSU_LANES));
                if (turn == LAST_TURN) begin
                    upd_vec[sel_warp]   = 1'b1;
                    stall_set[sel_warp] = (op == OP_LOAD);
                    next_state          = ST_SELECT;
                end
            end
        endcase
    end
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk
    import warp_sched_pkg::*;
#(
    parameter int WARPS     = 4,
    parameter int THREADS   = 32,
    parameter int LSU_LANES = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 disp_valid,
    input logic [$clog2(WARPS)-1:0]             disp_warp,
    input logic [3:0]                           disp_op,
    input logic [THREADS-1:0]                   disp_mask,
    input logic [$clog2(THREADS/LSU_LANES)-1:0] disp_turn,
    input logic                                 idle,
    input logic [WARPS-1:0]                     valid_vec,
    input logic [WARPS-1:0]                     stall_vec
);
    localparam int TURN_W = $clog2(THREADS / LSU_LANES);
    localparam logic [TURN_W-1:0] LAST_T = TURN_W'(THREADS / LSU_LANES - 1);
    localparam logic [THREADS-1:0] ONES8 = {{(THREADS-LSU_LANES){1'b0}}, {LSU_LANES{1'b1}}};

    a_r5_turn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_turn != '0) |->
            ($past(disp_valid) && disp_turn == $past(disp_turn) + 1'b1 && disp_warp == $past(disp_warp)));

    a_r5_turn_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && is_mem_op(disp_op) && disp_turn != LAST_T) |=>
            (disp_valid && disp_warp == $past(disp_warp)));

    a_r5_lane_slice: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && is_mem_op(disp_op)) |->
            ((disp_mask & ~(ONES8 << (int'(disp_turn) * LSU_LANES))) == '0));

    a_r6_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_turn == '0) |-> (valid_vec[disp_warp] && !stall_vec[disp_warp]));

    a_r6_load_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_op == OP_LOAD && disp_turn == LAST_T) |=> stall_vec[$past(disp_warp)]);

    a_r10_idle_none_ready: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> ((valid_vec & ~stall_vec) == '0 && !disp_valid));
endmodule

bind warp_sched warp_sched_chk #(
    .WARPS(WARPS), .THREADS(THREADS), .LSU_LANES(LSU_LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_warp  (disp_warp),
    .disp_op    (disp_op),
    .disp_mask  (disp_mask),
    .disp_turn  (disp_turn),
    .idle       (idle),
    .valid_vec  (valid_vec),
    .stall_vec  (stall_vec)
);

// File: tb/warp_sched_test.sv
module warp_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_en = 1'b0;
    logic [1:0]  launch_warp = '0;
    logic [5:0]  launch_pc = '0;
    logic [31:0] launch_mask = '0;
    logic [31:0] br_cond = '0;
    logic [3:0]  mem_done = '0;
    logic [5:0]  imem_addr;
    logic [19:0] imem_data;
    logic        disp_valid;
    logic [1:0]  disp_warp;
    logic [3:0]  disp_op;
    logic [4:0]  disp_rd, disp_rs;
    logic [31:0] disp_mask;
    logic [1:0]  disp_turn;
    logic        idle;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [19:0] prog [64];
    assign imem_data = prog[imem_addr];

    always #5 clk = ~clk;

    warp_sched uut (
        .clk(clk), .rst_n(rst_n), .launch_en(launch_en), .launch_warp(launch_warp),
        .launch_pc(launch_pc), .launch_mask(launch_mask), .br_cond(br_cond),
        .mem_done(mem_done), .imem_addr(imem_addr), .imem_data(imem_data),
        .disp_valid(disp_valid), .disp_warp(disp_warp), .disp_op(disp_op),
        .disp_rd(disp_rd), .disp_rs(disp_rs), .disp_mask(disp_mask),
        .disp_turn(disp_turn), .idle(idle)
    );

    // R11 encoding: op[19:16] rd[15:11] rs[10:6] tgt[5:0]; rd = address, rs = address+1
    function automatic logic [19:0] enc(logic [3:0] op, int at, int tgt);
        return {op, 5'(at), 5'(at + 1), 6'(tgt)};
    endfunction

    typedef struct packed {
        logic        ld;
        logic [1:0]  lw;
        logic [5:0]  lpc;
        logic [31:0] cond;
        logic [3:0]  md;
        logic        ev;
        logic [1:0]  ew;
        logic [3:0]  eop;
        logic [4:0]  erd;
        logic [31:0] emask;
        logic [1:0]  et;
    } vec_t;

    localparam int NV = 35;
    localparam logic [31:0] F = 32'hFFFF_FFFF;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 6'd8,  32'h0,         4'h0, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0000FFFF,  4'h0, 1'b1, 2'd0, 4'd3, 5'd8,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd0, 4'd0, 5'd9,  32'h0000FFFF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd0, 4'd0, 5'd10, 32'h0000FFFF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd0, 4'd0, 5'd11, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd0, 4'd6, 5'd12, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b1, 2'd1, 6'd16, 32'h0,         4'h0, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd4, 5'd16, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd0, 5'd17, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0000FFFF,  4'h0, 1'b1, 2'd1, 4'd5, 5'd18, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd0, 5'd17, 32'h0000FFFF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h000000FF,  4'h0, 1'b1, 2'd1, 4'd5, 5'd18, 32'h0000FFFF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd0, 5'd17, 32'h000000FF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd5, 5'd18, 32'h000000FF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd0, 5'd19, F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd1, 4'd6, 5'd20, F,             2'd0},
        '{1'b1, 2'd2, 6'd0,  32'h0,         4'h0, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b1, 2'd3, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd0, 5'd0,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd0, 5'd0,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd1, 5'd1,  32'h000000FF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd1, 5'd1,  32'h0000FF00,  2'd1},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd1, 5'd1,  32'h00FF0000,  2'd2},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd1, 5'd1,  32'hFF000000,  2'd3},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd1, 5'd1,  32'h000000FF,  2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd1, 5'd1,  32'h0000FF00,  2'd1},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd1, 5'd1,  32'h00FF0000,  2'd2},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd1, 5'd1,  32'hFF000000,  2'd3},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h8, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd0, 5'd2,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd3, 4'd6, 5'd3,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h4, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd0, 5'd2,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b1, 2'd2, 4'd6, 5'd3,  F,             2'd0},
        '{1'b0, 2'd0, 6'd0,  32'h0,         4'h0, 1'b0, 2'd0, 4'd0, 5'd0,  32'h0,         2'd0}
    };

    function automatic string row_req(int i);
        if (i < 7)  return "R7 R8 R3 if-reconverge";
        if (i < 17) return "R9 R8 loop-narrowing";
        return "R4 R5 R6 R10 rr-split-stall";
    endfunction

    task automatic drive(logic ld, logic [1:0] lw, logic [5:0] lpc, logic [31:0] lm,
                         logic [31:0] c, logic [3:0] md);
        @(negedge clk);
        launch_en   = ld;
        launch_warp = lw;
        launch_pc   = lpc;
        launch_mask = lm;
        br_cond     = c;
        mem_done    = md;
        #1;
    endtask

    task automatic expect_out(string req, logic ev, logic [1:0] ew, logic [3:0] eop,
                              logic [4:0] erd, logic [31:0] em, logic [1:0] et);
        logic bad;
        checks++;
        bad = (disp_valid !== ev) || (idle !== !ev);
        if (ev)
            bad = bad || (disp_warp !== ew) || (disp_op !== eop) || (disp_rd !== erd) ||
                  (disp_mask !== em) || (disp_turn !== et);
        if (bad) begin
            errors++;
            $display("FAIL %s: got v=%0b idle=%0b w=%0d op=%0d rd=%0d mask=%h turn=%0d, expected v=%0b w=%0d op=%0d rd=%0d mask=%h turn=%0d",
                     req, disp_valid, idle, disp_warp, disp_op, disp_rd, disp_mask, disp_turn,
                     ev, ew, eop, erd, em, et);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 64; a++) prog[a] = enc(4'd0, a, 0);
        prog[1]  = enc(4'd1, 1, 0);
        prog[3]  = enc(4'd6, 3, 0);
        prog[8]  = enc(4'd3, 8, 11);
        prog[12] = enc(4'd6, 12, 0);
        prog[16] = enc(4'd4, 16, 19);
        prog[18] = enc(4'd5, 18, 17);
        prog[20] = enc(4'd6, 20, 0);
        prog[24] = enc(4'd2, 24, 0);
        prog[26] = enc(4'd6, 26, 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: nothing resident after reset
        expect_out("R1 reset state", 1'b0, 2'd0, 4'd0, 5'd0, 32'h0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ld, TBL[i].lw, TBL[i].lpc, F, TBL[i].cond, TBL[i].md);
            expect_out(row_req(i), TBL[i].ev, TBL[i].ew, TBL[i].eop, TBL[i].erd, TBL[i].emask, TBL[i].et);
        end

        // R2: second launch into occupied slot 0 is ignored
        drive(1'b1, 2'd0, 6'd8, F, 32'h0, 4'h0);
        expect_out("R2 launch pending", 1'b0, 2'd0, 4'd0, 5'd0, 32'h0, 2'd0);
        drive(1'b1, 2'd0, 6'd0, 32'h1, 32'h0, 4'h0);
        expect_out("R2 occupied launch ignored", 1'b1, 2'd0, 4'd3, 5'd8, F, 2'd0);
        checks++;
        if (disp_rs !== 5'd9) begin
            errors++;
            $display("FAIL R11 rs field: got %0d expected 9", disp_rs);
        end
        // R7: condition all false, jump to target with mask kept
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R7 all-false jump", 1'b1, 2'd0, 4'd0, 5'd11, F, 2'd0);
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R10 exit", 1'b1, 2'd0, 4'd6, 5'd12, F, 2'd0);
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R10 idle after exit", 1'b0, 2'd0, 4'd0, 5'd0, 32'h0, 2'd0);

        // R5/R3: partial mask, store still spends all four turns; R6 store no stall
        drive(1'b1, 2'd1, 6'd24, 32'h0000000F, 32'h0, 4'h0);
        expect_out("R2 launch partial mask", 1'b0, 2'd0, 4'd0, 5'd0, 32'h0, 2'd0);
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R5 store turn0", 1'b1, 2'd1, 4'd2, 5'd24, 32'h0000000F, 2'd0);
        for (int t = 1; t < 4; t++) begin
            drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
            expect_out("R5 R3 empty store turn", 1'b1, 2'd1, 4'd2, 5'd24, 32'h0, 2'(t));
        end
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R6 store no stall", 1'b1, 2'd1, 4'd0, 5'd25, 32'h0000000F, 2'd0);
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R10 exit partial", 1'b1, 2'd1, 4'd6, 5'd26, 32'h0000000F, 2'd0);
        drive(1'b0, 2'd0, 6'd0, F, 32'h0, 4'h0);
        expect_out("R10 idle end", 1'b0, 2'd0, 4'd0, 5'd0, 32'h0, 2'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule